// File: doc/BRIEF.md
# Split Read Response Tag Matcher

This block keeps track of one master's outstanding split read transactions on a time-multiplexed address/data bus. When the master issues a read, the block hands out a free transaction ID and records how long the returned line will be. Data comes back later with no address cycle. Each return beat carries only the master ID and the transaction ID, so the block steers every beat into per-tag storage using that tag alone.

Each tag counts its own beats, so bursts for different tags may interleave beat by beat. When a tag's last beat is stored, the block frees the tag and presents the whole line once, with its tag and size code. Beats that belong to another master are dropped. A beat that names one of this master's tags which is not outstanding sets a sticky error. When every tag is busy, a stall output tells the issuer to hold off.

Top module: `split_resp_matcher`

## Requirements
- R1: After reset, `alloc_tid` is 0, `no_free` is 0, `line_valid` is 0 and `tag_err` is 0. Reset also frees every tag and clears `tag_err`.
- R2: While `no_free` is low, `alloc_tid` shows the lowest-numbered free tag. A cycle with `req_valid` high claims that tag, and from the next cycle `alloc_tid` shows the next lowest free tag.
- R3: `no_free` is high exactly when all 2^TID_W tags are outstanding. A `req_valid` while `no_free` is high claims nothing and changes no state.
- R4: The size code given at allocation sets the line length: code 0 is 2 beats, code 1 is 4 beats, code 2 is 8 beats. The delivered `line_data` holds beat k in bits [64k+63:64k], and beats at or above the line length read as zero.
- R5: `line_valid` goes high on the first rising edge after the edge that stores a tag's final beat, and stays high for one cycle, with `line_tid` and `line_size` naming the tag and its size code.
- R6: Beats for different outstanding tags may interleave in any order. Each tag's beats are assembled in their own arrival order.
- R7: A tag stays allocated until its final beat is stored. On that edge it becomes free again and can be handed out by `alloc_tid`.
- R8: A return beat whose `rsp_mid` differs from the parameter `MY_MID` has no effect: no data is stored, no beat count advances and `tag_err` does not change.
- R9: A return beat with `rsp_mid` equal to `MY_MID` whose `rsp_tid` is not outstanding sets `tag_err`. The beat is discarded and `tag_err` stays high until reset.
- R10: Size code 3 is treated as an 8-beat line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Issuer claims the tag shown on `alloc_tid` this cycle |
| req_size | input | 2 | Line size code for the new request |
| alloc_tid | output | TID_W | Lowest free transaction ID |
| no_free | output | 1 | All transaction IDs are outstanding; the issuer must stall |
| rsp_valid | input | 1 | Data-return beat present on the bus |
| rsp_mid | input | MID_W | Master ID carried by the beat |
| rsp_tid | input | TID_W | Transaction ID carried by the beat |
| rsp_data | input | DATA_W | One doubleword of returned data |
| line_valid | output | 1 | One-cycle strobe: a completed line is presented |
| line_tid | output | TID_W | Tag of the completed line |
| line_size | output | 2 | Size code of the completed line |
| line_data | output | 8*DATA_W | Assembled line, beat 0 in the low bits |
| tag_err | output | 1 | Sticky flag: a beat hit a tag that was not outstanding |

## Verification
The assertions assume that `rsp_valid` and the tag fields are never unknown once reset is released. They also assume that a completed line comes only from a beat carrying this master's ID two cycles earlier, and that the error flag rises only because of a beat to an idle tag. The stimulus drives every input on the falling clock edge. It returns data only to tags the bench has allocated, with exactly the beat count of their size code. The only exceptions are one deliberate beat to a freed tag and beats carrying a foreign master ID. While the stall output is high, the bench issues one request on purpose to show that it has no effect.

// File: rtl/split_resp_pkg.sv
package split_resp_pkg;

  localparam int MAX_BEATS = 8;
  localparam int BEAT_W    = $clog2(MAX_BEATS);

  typedef logic [1:0] size_code_t;

  // Size code to beat count: 0 -> 2, 1 -> 4, 2 and 3 -> 8.
  function automatic logic [BEAT_W:0] beats_of(input size_code_t code);
    case (code)
      2'd0:    beats_of = (BEAT_W+1)'(2);
      2'd1:    beats_of = (BEAT_W+1)'(4);
      default: beats_of = (BEAT_W+1)'(8);
    endcase
  endfunction

endpackage

// File: rtl/srm_tag_table.sv
module srm_tag_table
  import split_resp_pkg::*;
#(
  parameter int TID_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  alloc_en,
  input  size_code_t            alloc_size,
  input  logic                  hit_en,
  input  logic [TID_W-1:0]      hit_tid,
  output logic                  hit_busy,
  output logic [BEAT_W-1:0]     hit_beat,
  output logic                  hit_last,
  output size_code_t            hit_size,
  output logic [TID_W-1:0]      alloc_tid,
  output logic                  no_free,
  output logic [(1<<TID_W)-1:0] busy_vec
);

  localparam int NTAG = 1 << TID_W;

  logic [NTAG-1:0]   busy_q, busy_nxt;
  size_code_t        size_q [NTAG];
  logic [BEAT_W-1:0] cnt_q  [NTAG];
  logic [TID_W-1:0]  free_q, free_nxt;
  logic              full_q, full_nxt;
  logic              take, step, done;

  assign hit_busy = busy_q[hit_tid];
  assign hit_beat = cnt_q[hit_tid];
  assign hit_size = size_q[hit_tid];
  assign hit_last = ({1'b0, hit_beat} == beats_of(hit_size) - 1'b1);

  assign take = alloc_en && !full_q;
  assign step = hit_en && hit_busy;
  assign done = step && hit_last;

  always_comb begin
    busy_nxt = busy_q;
    if (done) busy_nxt[hit_tid] = 1'b0;
    if (take) busy_nxt[free_q]  = 1'b1;
  end

  // Lowest free tag of the next state, registered with the state itself.
  always_comb begin
    free_nxt = '0;
    for (int i = NTAG - 1; i >= 0; i--) begin
      if (!busy_nxt[i]) free_nxt = TID_W'(i);
    end
    full_nxt = &busy_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      free_q <= '0;
      full_q <= 1'b0;
      for (int i = 0; i < NTAG; i++) begin
        size_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else begin
      busy_q <= busy_nxt;
      free_q <= free_nxt;
      full_q <= full_nxt;
      if (step) cnt_q[hit_tid] <= hit_last ? '0 : hit_beat + 1'b1;
      if (take) begin
        size_q[free_q] <= alloc_size;
        cnt_q[free_q]  <= '0;
      end
    end
  end

  assign alloc_tid = free_q;
  assign no_free   = full_q;
  assign busy_vec  = busy_q;

endmodule

// File: rtl/srm_beat_store.sv
module srm_beat_store
  import split_resp_pkg::*;
#(
  parameter int TID_W  = 3,
  parameter int DATA_W = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [BEAT_W-1:0]             wr_beat,
  input  logic [TID_W-1:0]              wr_tid,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          rd_en,
  input  logic [TID_W-1:0]              rd_tid,
  input  size_code_t                    rd_size,
  output logic [MAX_BEATS*DATA_W-1:0]   rd_line
);

  localparam int NTAG = 1 << TID_W;

  // One bank per beat position, indexed by tag, so a full line reads in one cycle.
  for (genvar b = 0; b < MAX_BEATS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [NTAG];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_beat == BEAT_W'(b))) mem[wr_tid] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        rd_q <= '0;
      end else if (rd_en) begin
        rd_q <= ((BEAT_W+1)'(b) < beats_of(rd_size)) ? mem[rd_tid] : '0;
      end
    end

    assign rd_line[b*DATA_W +: DATA_W] = rd_q;
  end

endmodule

// File: rtl/split_resp_matcher.sv
module split_resp_matcher
  import split_resp_pkg::*;
#(
  parameter int MID_W  = 3,
  parameter int TID_W  = 3,
  parameter int DATA_W = 64,
  parameter int MY_MID = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [1:0]                  req_size,
  output logic [TID_W-1:0]            alloc_tid,
  output logic                        no_free,
  input  logic                        rsp_valid,
  input  logic [MID_W-1:0]            rsp_mid,
  input  logic [TID_W-1:0]            rsp_tid,
  input  logic [DATA_W-1:0]           rsp_data,
  output logic                        line_valid,
  output logic [TID_W-1:0]            line_tid,
  output logic [1:0]                  line_size,
  output logic [8*DATA_W-1:0]         line_data,
  output logic                        tag_err
);

  localparam int NTAG = 1 << TID_W;

  logic              own_beat;
  logic              hit_busy, hit_last, wr_en;
  logic [BEAT_W-1:0] hit_beat;
  size_code_t        hit_size;
  logic [NTAG-1:0]   busy_vec;

  logic              fin_q;
  logic [TID_W-1:0]  fin_tid_q;
  size_code_t        fin_size_q;
  logic              lv_q;
  logic [TID_W-1:0]  ltid_q;
  size_code_t        lsize_q;
  logic              err_q;

  assign own_beat = rsp_valid && (rsp_mid == MID_W'(MY_MID));
  assign wr_en    = own_beat && hit_busy;

  srm_tag_table #(.TID_W(TID_W)) u_tags (
    .clk        (clk),
    .rst        (rst),
    .alloc_en   (req_valid),
    .alloc_size (req_size),
    .hit_en     (own_beat),
    .hit_tid    (rsp_tid),
    .hit_busy   (hit_busy),
    .hit_beat   (hit_beat),
    .hit_last   (hit_last),
    .hit_size   (hit_size),
    .alloc_tid  (alloc_tid),
    .no_free    (no_free),
    .busy_vec   (busy_vec)
  );

  srm_beat_store #(.TID_W(TID_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_beat (hit_beat),
    .wr_tid  (rsp_tid),
    .wr_data (rsp_data),
    .rd_en   (fin_q),
    .rd_tid  (fin_tid_q),
    .rd_size (fin_size_q),
    .rd_line (line_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fin_q      <= 1'b0;
      fin_tid_q  <= '0;
      fin_size_q <= '0;
      lv_q       <= 1'b0;
      ltid_q     <= '0;
      lsize_q    <= '0;
      err_q      <= 1'b0;
    end else begin
      fin_q <= wr_en && hit_last;
      if (wr_en && hit_last) begin
        fin_tid_q  <= rsp_tid;
        fin_size_q <= hit_size;
      end
      lv_q <= fin_q;
      if (fin_q) begin
        ltid_q  <= fin_tid_q;
        lsize_q <= fin_size_q;
      end
      if (own_beat && !hit_busy) err_q <= 1'b1;
    end
  end

  assign line_valid = lv_q;
  assign line_tid   = ltid_q;
  assign line_size  = lsize_q;
  assign tag_err    = err_q;

endmodule

// File: rtl/split_resp_matcher_chk.sv
module split_resp_matcher_chk #(
  parameter int MID_W  = 3,
  parameter int TID_W  = 3,
  parameter int MY_MID = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic [TID_W-1:0]      alloc_tid,
  input logic                  no_free,
  input logic                  rsp_valid,
  input logic [MID_W-1:0]      rsp_mid,
  input logic [TID_W-1:0]      rsp_tid,
  input logic                  line_valid,
  input logic                  tag_err,
  input logic [(1<<TID_W)-1:0] busy_vec
);

  AST_FREE_TAG_IDLE: assert property (@(posedge clk) disable iff (rst)
    !no_free |-> !busy_vec[alloc_tid]); // R2

  AST_FULL_ALL_BUSY: assert property (@(posedge clk) disable iff (rst)
    no_free |-> (&busy_vec)); // R3

  AST_LINE_FROM_OWN: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> ($past(rsp_valid, 2) && ($past(rsp_mid, 2) == MID_W'(MY_MID)))); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    tag_err |=> tag_err); // R9

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(tag_err) |-> $past(rsp_valid && (rsp_mid == MID_W'(MY_MID)) && !busy_vec[rsp_tid])); // R9

endmodule

bind split_resp_matcher split_resp_matcher_chk #(
  .MID_W(MID_W), .TID_W(TID_W), .MY_MID(MY_MID)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .alloc_tid  (alloc_tid),
  .no_free    (no_free),
  .rsp_valid  (rsp_valid),
  .rsp_mid    (rsp_mid),
  .rsp_tid    (rsp_tid),
  .line_valid (line_valid),
  .tag_err    (tag_err),
  .busy_vec   (busy_vec)
);

// File: tb/split_resp_matcher_test.sv
module split_resp_matcher_test;

  localparam int MID_W = 3, TID_W = 3, DATA_W = 64, MY_MID = 5, NTAG = 8;
  localparam logic [2:0] OWN = 3'd5, OTHER = 3'd2;

  // Vector: size code [21:20], expected beat count [19:16], data seed [15:0]
  localparam logic [21:0] VEC [0:5] = '{
    {2'd0, 4'd2, 16'h1A00},
    {2'd1, 4'd4, 16'h2B00},
    {2'd2, 4'd8, 16'h3C00},
    {2'd3, 4'd8, 16'h4D00},
    {2'd0, 4'd2, 16'h5E00},
    {2'd1, 4'd4, 16'h6F00}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rst = 1'b1;
  logic                 req_valid = 1'b0;
  logic [1:0]           req_size = '0;
  logic [TID_W-1:0]     alloc_tid;
  logic                 no_free;
  logic                 rsp_valid = 1'b0;
  logic [MID_W-1:0]     rsp_mid = '0;
  logic [TID_W-1:0]     rsp_tid = '0;
  logic [DATA_W-1:0]    rsp_data = '0;
  logic                 line_valid;
  logic [TID_W-1:0]     line_tid;
  logic [1:0]           line_size;
  logic [8*DATA_W-1:0]  line_data;
  logic                 tag_err;

  int n_chk = 0;
  int n_fail = 0;

  logic [DATA_W-1:0] cap [NTAG][8];
  logic              got [NTAG];

  split_resp_matcher #(.MID_W(MID_W), .TID_W(TID_W), .DATA_W(DATA_W), .MY_MID(MY_MID)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_size(req_size),
    .alloc_tid(alloc_tid), .no_free(no_free), .rsp_valid(rsp_valid),
    .rsp_mid(rsp_mid), .rsp_tid(rsp_tid), .rsp_data(rsp_data),
    .line_valid(line_valid), .line_tid(line_tid), .line_size(line_size),
    .line_data(line_data), .tag_err(tag_err)
  );

  always @(negedge clk) begin
    if (line_valid) begin
      got[line_tid] = 1'b1;
      for (int k = 0; k < 8; k++) cap[line_tid][k] = line_data[k*DATA_W +: DATA_W];
    end
  end

  function automatic logic [63:0] pat(input logic [15:0] seed, input int k);
    pat = {seed, 40'hC0FFEE0000, 8'(k)};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic send_beat(input logic [2:0] mid, input logic [2:0] tid, input logic [63:0] d);
    rsp_valid = 1'b1; rsp_mid = mid; rsp_tid = tid; rsp_data = d;
    step();
    rsp_valid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int t = 0; t < NTAG; t++) got[t] = 1'b0;
    @(negedge clk);
    step();
    step();
    rst = 1'b0;
    // R1 reset state
    chk("R1 alloc_tid", 64'(alloc_tid), 64'd0);
    chk("R1 no_free", 64'(no_free), 64'd0);
    chk("R1 line_valid", 64'(line_valid), 64'd0);
    chk("R1 tag_err", 64'(tag_err), 64'd0);

    // Vector table: one full read per entry on tag 0
    for (int v = 0; v < 6; v++) begin
      logic [1:0]  code;
      int          nb;
      logic [15:0] seed;
      code = VEC[v][21:20];
      nb   = int'(VEC[v][19:16]);
      seed = VEC[v][15:0];
      req_valid = 1'b1; req_size = code;
      chk("R2 first free tag", 64'(alloc_tid), 64'd0);
      step();
      req_valid = 1'b0;
      chk("R2 next free tag", 64'(alloc_tid), 64'd1);
      for (int k = 0; k < nb; k++) begin
        send_beat(OWN, 3'd0, pat(seed, k));
        if (k < nb - 1) chk("R7 tag held mid-burst", 64'(alloc_tid), 64'd1);
      end
      chk("R7 tag freed after last beat", 64'(alloc_tid), 64'd0);
      chk("R5 no line yet", 64'(line_valid), 64'd0);
      step();
      chk("R5 line strobe", 64'(line_valid), 64'd1);
      chk("R4 line tid", 64'(line_tid), 64'd0);
      chk("R4 line size", 64'(line_size), 64'(code));
      for (int k = 0; k < 8; k++)
        chk(code == 2'd3 ? "R10 beat" : "R4 beat", line_data[k*DATA_W +: DATA_W],
            (k < nb) ? pat(seed, k) : 64'd0);
      step();
      chk("R5 one-cycle strobe", 64'(line_valid), 64'd0);
    end

    // Fill every tag: tag i gets size code i%4
    for (int i = 0; i < NTAG; i++) begin
      req_valid = 1'b1; req_size = 2'(i % 4);
      chk("R2 sequential alloc", 64'(alloc_tid), 64'(i));
      chk("R3 not full yet", 64'(no_free), 64'd0);
      step();
    end
    req_valid = 1'b0;
    chk("R3 full", 64'(no_free), 64'd1);
    req_valid = 1'b1; req_size = 2'd0;
    step();
    step();
    req_valid = 1'b0;
    chk("R3 request while full ignored", 64'(no_free), 64'd1);

    // Interleave tag 3 (code 3, 8 beats) with tag 1 (code 1, 4 beats) plus a foreign beat
    for (int i = 0; i < 8; i++) begin
      send_beat(OWN, 3'd3, pat(16'h3300, i));
      if (i < 4) begin
        if (i == 1) begin
          send_beat(OTHER, 3'd1, pat(16'hBAD0, i));
          chk("R8 foreign beat no error", 64'(tag_err), 64'd0);
        end
        if (i == 3) chk("R7 held until last beat", 64'(no_free), 64'd1);
        send_beat(OWN, 3'd1, pat(16'h1100, i));
        if (i == 3) begin
          chk("R7 freed tag visible", 64'(no_free), 64'd0);
          chk("R7 freed tag reusable", 64'(alloc_tid), 64'd1);
        end
      end
    end
    step();
    step();
    chk("R6 tag1 line seen", 64'(got[1]), 64'd1);
    chk("R6 tag3 line seen", 64'(got[3]), 64'd1);
    for (int k = 0; k < 8; k++) begin
      chk("R6 R8 tag1 beat", cap[1][k], (k < 4) ? pat(16'h1100, k) : 64'd0);
      chk("R6 R10 tag3 beat", cap[3][k], pat(16'h3300, k));
    end

    // Foreign beat to an idle tag, then own beat to an idle tag
    send_beat(OTHER, 3'd1, 64'hDEAD);
    chk("R8 foreign to idle tag", 64'(tag_err), 64'd0);
    got[1] = 1'b0;
    send_beat(OWN, 3'd1, 64'hBEEF);
    chk("R9 error set", 64'(tag_err), 64'd1);
    step();
    step();
    step();
    chk("R9 error sticky", 64'(tag_err), 64'd1);
    chk("R9 beat discarded", 64'(got[1]), 64'd0);
    chk("R9 no allocation from bad beat", 64'(alloc_tid), 64'd1);

    // Reset clears everything
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R1 error cleared", 64'(tag_err), 64'd0);
    chk("R1 tags freed", 64'(no_free), 64'd0);
    chk("R1 alloc restart", 64'(alloc_tid), 64'd0);
    chk("R1 no line", 64'(line_valid), 64'd0);

    summary();
    $finish;
  end

endmodule